// File: doc/BRIEF.md
# Dispatch group slot allocator

This block sits between an in-order buffer of decoded internal operations and the issue stage of an out-of-order core. Each cycle it looks at the oldest operations, up to five of them, and packs them into one five-slot dispatch group. The group is registered, so it appears on the outputs one clock after the operations are offered. Each occupied slot carries a valid flag, the operation tag, the operation kind, the cluster field of the operation, and a unit select bit. The unit select bit picks one of the two identical execution units of the cluster, and it depends only on the position of the slot.

The placement is combinational and runs strictly in program order. Slot 1 through slot 4 take ordinary operations. Slot 5 takes only a branch. A cracked operation needs two adjacent slots, and a serializing operation needs all four of the lower slots. Some operations may sit only in slot 1. When an operation does not fit, that operation and every younger one are held back. The block reports at once how many of the oldest operations it accepted, and the upstream buffer removes exactly that many.

Top module: `dispatch_group_alloc`

## Requirements
- R1: `take_count` is the number of operations placed this cycle. It is at most 5 and never more than `win_count`, and a `win_count` above 5 counts as 5. The accepted operations are always the oldest ones, window entries 0 to `take_count`-1. Entries at or above `win_count` are ignored.
- R2: Operations take slots in program order. An operation never uses a slot with a lower number than the slots of an older operation, and slots skipped before a branch stay invalid.
- R3: A branch (kind 4) is placed only in slot 5 (output index 4), whatever slots are still free. Any lower slot that is still free stays invalid, and no younger operation is accepted in that cycle.
- R4: A valid operation in slot 1 or slot 4 has `grp_unit`=0. A valid operation in slot 2 or slot 3 has `grp_unit`=1. A branch in slot 5 has `grp_unit`=0, and so does every invalid slot.
- R5: A cracked operation (kind 1) fills two adjacent slots within slots 1 to 4, and both slots carry its tag. If fewer than two of those slots are left, it is held along with every younger operation.
- R6: A four-slot operation (kind 2) is placed only into an empty group and fills slots 1 to 4. Otherwise it is held for the next cycle.
- R7: A slot-1-only operation (kind 3) is placed only into an empty group, in slot 1. Younger operations may follow it in slots 2 to 5.
- R8: A single-slot operation (kind 0) takes the next free slot among slots 1 to 4. When slots 1 to 4 are full it is held, and slot 5 holds nothing but a branch.
- R9: While `rst` is high, `take_count` is 0. After a reset cycle every `grp_valid` bit is 0, and tag, kind, cluster and unit read 0.
- R10: Kind codes 5, 6 and 7 are placed as single-slot operations. Their code is passed unchanged to `grp_kind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_count | input | 3 | Number of valid operations in the window, oldest first |
| win_kind | input | 5x3 | Kind code of each window entry |
| win_cluster | input | 5xCLU_W | Cluster field of each entry, passed through |
| win_tag | input | 5xTAG_W | Tag of each entry |
| take_count | output | 3 | Operations accepted this cycle, combinational |
| grp_valid | output | 5 | Registered slot valid flags, index 0 is slot 1 |
| grp_kind | output | 5x3 | Kind code of the operation in each slot |
| grp_cluster | output | 5xCLU_W | Cluster field of the operation in each slot |
| grp_tag | output | 5xTAG_W | Tag of the operation in each slot |
| grp_unit | output | 5 | Unit select per slot, 0 = first unit, 1 = second |

## Verification
The bench goes after the places where a group closes early. A branch that comes first must leave slots 1 to 4 empty. A design that packed the branch into the next free slot would show a branch in a low slot, and its unit bit would be wrong. A cracked operation arriving when only slot 4 is free must be held. A design that wrapped the pair into slot 5 would let a non-branch into the branch slot and report one operation too many. Four-slot and slot-1-only operations that come behind an older operation must be held, or a design that ignores the empty-group rule takes them. The bench also offers a window count above five, with stale entries beyond the count, to catch a wrong clamp or entries that leak past the count.

// File: rtl/dga_pkg.sv
package dga_pkg;

    localparam int NSLOT   = 5;   // dispatch slots per group
    localparam int NLOW    = 4;   // slots usable by non-branch ops
    localparam int KIND_W  = 3;
    localparam int CNT_W   = 3;
    localparam int IDX_W   = 3;

    typedef enum logic [KIND_W-1:0] {
        OPK_SINGLE = 3'd0,
        OPK_PAIR   = 3'd1,
        OPK_QUAD   = 3'd2,
        OPK_HEAD   = 3'd3,
        OPK_BRANCH = 3'd4
    } op_kind_e;

    // Placement record: which window entry fills a slot
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] src;
    } place_t;

    // Reserved codes behave as single-slot ops (R10)
    function automatic op_kind_e kind_of(input logic [KIND_W-1:0] code);
        op_kind_e k;
        case (code)
            3'd1:    k = OPK_PAIR;
            3'd2:    k = OPK_QUAD;
            3'd3:    k = OPK_HEAD;
            3'd4:    k = OPK_BRANCH;
            default: k = OPK_SINGLE;
        endcase
        return k;
    endfunction

    // Slots 2 and 3 (index 1, 2) drive the second unit of a pair (R4)
    function automatic logic unit_of_slot(input int slot);
        return (slot == 1) || (slot == 2);
    endfunction

endpackage

// File: rtl/dga_place.sv
module dga_place
    import dga_pkg::*;
(
    input  logic [CNT_W-1:0]              win_count,
    input  logic [NSLOT-1:0][KIND_W-1:0]  win_kind,
    output place_t [NSLOT-1:0]            slot_map,
    output logic [CNT_W-1:0]              taken
);

    always_comb begin
        int  pos;
        int  lim;
        int  n;
        logic stop;
        pos  = 0;
        n    = 0;
        stop = 1'b0;
        lim  = (win_count > CNT_W'(NSLOT)) ? NSLOT : int'(win_count);   // R1
        for (int s = 0; s < NSLOT; s++) begin
            slot_map[s] = '0;
        end
        for (int i = 0; i < NSLOT; i++) begin
            if (!stop && (i < lim)) begin
                case (kind_of(win_kind[i]))
                    OPK_SINGLE: begin                      // R8
                        if (pos < NLOW) begin
                            slot_map[pos] = '{vld: 1'b1, src: IDX_W'(i)};
                            pos = pos + 1;
                            n   = n + 1;
                        end else begin
                            stop = 1'b1;
                        end
                    end
                    OPK_PAIR: begin                        // R5
                        if (pos + 2 <= NLOW) begin
                            slot_map[pos]   = '{vld: 1'b1, src: IDX_W'(i)};
                            slot_map[pos+1] = '{vld: 1'b1, src: IDX_W'(i)};
                            pos = pos + 2;
                            n   = n + 1;
                        end else begin
                            stop = 1'b1;
                        end
                    end
                    OPK_QUAD: begin                        // R6
                        if (pos == 0) begin
                            for (int s = 0; s < NLOW; s++) begin
                                slot_map[s] = '{vld: 1'b1, src: IDX_W'(i)};
                            end
                            pos = NLOW;
                            n   = n + 1;
                        end else begin
                            stop = 1'b1;
                        end
                    end
                    OPK_HEAD: begin                        // R7
                        if (pos == 0) begin
                            slot_map[0] = '{vld: 1'b1, src: IDX_W'(i)};
                            pos = 1;
                            n   = n + 1;
                        end else begin
                            stop = 1'b1;
                        end
                    end
                    default: begin                         // branch, R3
                        slot_map[NSLOT-1] = '{vld: 1'b1, src: IDX_W'(i)};
                        pos  = NSLOT;
                        n    = n + 1;
                        stop = 1'b1;
                    end
                endcase
            end
        end
        taken = CNT_W'(n);
    end

endmodule

// File: rtl/dga_steer.sv
module dga_steer
    import dga_pkg::*;
(
    input  place_t [NSLOT-1:0] slot_map,
    output logic   [NSLOT-1:0] unit_sel
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic SECOND = unit_of_slot(s);
        assign unit_sel[s] = slot_map[s].vld & SECOND;   // R4
    end

endmodule

// File: rtl/dga_group_reg.sv
module dga_group_reg
    import dga_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int CLU_W = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NSLOT-1:0]                nxt_valid,
    input  logic [NSLOT-1:0][KIND_W-1:0]    nxt_kind,
    input  logic [NSLOT-1:0][CLU_W-1:0]     nxt_cluster,
    input  logic [NSLOT-1:0][TAG_W-1:0]     nxt_tag,
    input  logic [NSLOT-1:0]                nxt_unit,
    output logic [NSLOT-1:0]                q_valid,
    output logic [NSLOT-1:0][KIND_W-1:0]    q_kind,
    output logic [NSLOT-1:0][CLU_W-1:0]     q_cluster,
    output logic [NSLOT-1:0][TAG_W-1:0]     q_tag,
    output logic [NSLOT-1:0]                q_unit
);

    always_ff @(posedge clk) begin
        if (rst) begin                                   // R9
            q_valid   <= '0;
            q_kind    <= '0;
            q_cluster <= '0;
            q_tag     <= '0;
            q_unit    <= '0;
        end else begin
            q_valid   <= nxt_valid;
            q_kind    <= nxt_kind;
            q_cluster <= nxt_cluster;
            q_tag     <= nxt_tag;
            q_unit    <= nxt_unit;
        end
    end

endmodule

// File: rtl/dispatch_group_alloc.sv
module dispatch_group_alloc
    import dga_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int CLU_W = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [CNT_W-1:0]                     win_count,
    input  logic [NSLOT-1:0][KIND_W-1:0]         win_kind,
    input  logic [NSLOT-1:0][CLU_W-1:0]          win_cluster,
    input  logic [NSLOT-1:0][TAG_W-1:0]          win_tag,
    output logic [CNT_W-1:0]                     take_count,
    output logic [NSLOT-1:0]                     grp_valid,
    output logic [NSLOT-1:0][KIND_W-1:0]         grp_kind,
    output logic [NSLOT-1:0][CLU_W-1:0]          grp_cluster,
    output logic [NSLOT-1:0][TAG_W-1:0]          grp_tag,
    output logic [NSLOT-1:0]                     grp_unit
);

    place_t [NSLOT-1:0]              slot_map;
    logic   [CNT_W-1:0]              taken;
    logic   [NSLOT-1:0]              unit_sel;
    logic   [NSLOT-1:0]              nxt_valid;
    logic   [NSLOT-1:0][KIND_W-1:0]  nxt_kind;
    logic   [NSLOT-1:0][CLU_W-1:0]   nxt_cluster;
    logic   [NSLOT-1:0][TAG_W-1:0]   nxt_tag;

    dga_place u_place (
        .win_count (win_count),
        .win_kind  (win_kind),
        .slot_map  (slot_map),
        .taken     (taken)
    );

    dga_steer u_steer (
        .slot_map (slot_map),
        .unit_sel (unit_sel)
    );

    // Gather the fields of the selected window entry into each slot
    for (genvar s = 0; s < NSLOT; s++) begin : g_gather
        logic [IDX_W-1:0] sel;
        assign sel            = slot_map[s].src;
        assign nxt_valid[s]   = slot_map[s].vld;
        assign nxt_kind[s]    = slot_map[s].vld ? win_kind[sel]    : '0;
        assign nxt_cluster[s] = slot_map[s].vld ? win_cluster[sel] : '0;
        assign nxt_tag[s]     = slot_map[s].vld ? win_tag[sel]     : '0;
    end

    // No operations leave the buffer during reset (R9)
    assign take_count = rst ? '0 : taken;

    dga_group_reg #(
        .TAG_W (TAG_W),
        .CLU_W (CLU_W)
    ) u_group (
        .clk         (clk),
        .rst         (rst),
        .nxt_valid   (nxt_valid),
        .nxt_kind    (nxt_kind),
        .nxt_cluster (nxt_cluster),
        .nxt_tag     (nxt_tag),
        .nxt_unit    (unit_sel),
        .q_valid     (grp_valid),
        .q_kind      (grp_kind),
        .q_cluster   (grp_cluster),
        .q_tag       (grp_tag),
        .q_unit      (grp_unit)
    );

endmodule

// File: rtl/dga_checker.sv
module dga_checker
    import dga_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int CLU_W = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [CNT_W-1:0]                     win_count,
    input  logic [CNT_W-1:0]                     take_count,
    input  logic [NSLOT-1:0]                     grp_valid,
    input  logic [NSLOT-1:0][KIND_W-1:0]         grp_kind,
    input  logic [NSLOT-1:0][TAG_W-1:0]          grp_tag,
    input  logic [NSLOT-1:0]                     grp_unit
);

    always @(posedge clk) begin
        if (rst) begin
            AST_NO_TAKE_IN_RESET: assert (take_count == '0); // R9
        end
    end

    AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (take_count <= win_count) && (take_count <= CNT_W'(NSLOT))); // R1

    AST_TAKE_FILLS_GROUP: assert property (@(posedge clk) disable iff (rst)
        (take_count != '0) |=> (grp_valid != '0)); // R1

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (grp_valid == '0) && (grp_tag == '0)); // R9

    AST_BRANCH_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
        !((grp_valid[0] && grp_kind[0] == 3'd4) || (grp_valid[1] && grp_kind[1] == 3'd4) ||
          (grp_valid[2] && grp_kind[2] == 3'd4) || (grp_valid[3] && grp_kind[3] == 3'd4))); // R3

    AST_LAST_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
        grp_valid[4] |-> (grp_kind[4] == 3'd4)); // R8

    AST_UNIT_SLOT2: assert property (@(posedge clk) disable iff (rst)
        grp_valid[1] |-> grp_unit[1]); // R4

    AST_UNIT_SLOT3: assert property (@(posedge clk) disable iff (rst)
        grp_valid[2] |-> grp_unit[2]); // R4

    AST_UNIT_OUTER: assert property (@(posedge clk) disable iff (rst)
        !grp_unit[0] && !grp_unit[3] && !grp_unit[4]); // R4

    AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        (grp_valid[3] && grp_kind[3] == 3'd1) |-> (grp_valid[2] && grp_kind[2] == 3'd1)); // R5

    AST_QUAD_FULL: assert property (@(posedge clk) disable iff (rst)
        (grp_valid[0] && grp_kind[0] == 3'd2) |->
            ((&grp_valid[3:0]) && grp_tag[3] == grp_tag[0])); // R6

    AST_HEAD_FIRST_SLOT: assert property (@(posedge clk) disable iff (rst)
        !((grp_valid[1] && grp_kind[1] == 3'd3) || (grp_valid[2] && grp_kind[2] == 3'd3) ||
          (grp_valid[3] && grp_kind[3] == 3'd3))); // R7

endmodule

bind dispatch_group_alloc dga_checker #(
    .TAG_W (TAG_W),
    .CLU_W (CLU_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .win_count  (win_count),
    .take_count (take_count),
    .grp_valid  (grp_valid),
    .grp_kind   (grp_kind),
    .grp_tag    (grp_tag),
    .grp_unit   (grp_unit)
);

// File: tb/dispatch_group_alloc_tb.sv
module dispatch_group_alloc_tb;

    localparam int TAG_W = 8;
    localparam int CLU_W = 2;
    localparam int NV    = 17;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  cnt;
        logic [14:0] kinds;   // {op4..op0}
        logic [2:0]  take;
        logic [14:0] map;     // {slot5..slot1}, 7 = empty
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'd8,  3'd5, {3'd0,3'd0,3'd0,3'd0,3'd0}, 3'd4, {3'd7,3'd3,3'd2,3'd1,3'd0}}, // R8 slot 5 refuses single
        '{4'd3,  3'd5, {3'd4,3'd0,3'd0,3'd0,3'd0}, 3'd5, {3'd4,3'd3,3'd2,3'd1,3'd0}}, // R3 full group
        '{4'd3,  3'd5, {3'd0,3'd0,3'd0,3'd0,3'd4}, 3'd1, {3'd0,3'd7,3'd7,3'd7,3'd7}}, // R3 branch first
        '{4'd2,  3'd5, {3'd0,3'd0,3'd0,3'd4,3'd0}, 3'd2, {3'd1,3'd7,3'd7,3'd7,3'd0}}, // R2 skipped slots
        '{4'd5,  3'd5, {3'd0,3'd0,3'd1,3'd0,3'd1}, 3'd2, {3'd7,3'd7,3'd1,3'd0,3'd0}}, // R5 pair held at slot 4
        '{4'd5,  3'd5, {3'd0,3'd0,3'd0,3'd1,3'd0}, 3'd3, {3'd7,3'd2,3'd1,3'd1,3'd0}}, // R5 pair mid
        '{4'd6,  3'd5, {3'd0,3'd0,3'd0,3'd4,3'd2}, 3'd2, {3'd1,3'd0,3'd0,3'd0,3'd0}}, // R6 quad then branch
        '{4'd6,  3'd5, {3'd0,3'd0,3'd0,3'd2,3'd0}, 3'd1, {3'd7,3'd7,3'd7,3'd7,3'd0}}, // R6 quad held
        '{4'd7,  3'd5, {3'd0,3'd0,3'd0,3'd0,3'd3}, 3'd4, {3'd7,3'd3,3'd2,3'd1,3'd0}}, // R7 head then followers
        '{4'd7,  3'd5, {3'd0,3'd0,3'd0,3'd3,3'd0}, 3'd1, {3'd7,3'd7,3'd7,3'd7,3'd0}}, // R7 head held
        '{4'd1,  3'd2, {3'd4,3'd4,3'd4,3'd0,3'd0}, 3'd2, {3'd7,3'd7,3'd7,3'd1,3'd0}}, // R1 stale entries ignored
        '{4'd1,  3'd0, {3'd0,3'd0,3'd0,3'd0,3'd0}, 3'd0, {3'd7,3'd7,3'd7,3'd7,3'd7}}, // R1 empty window
        '{4'd10, 3'd5, {3'd0,3'd0,3'd7,3'd6,3'd5}, 3'd4, {3'd7,3'd3,3'd2,3'd1,3'd0}}, // R10 reserved codes
        '{4'd5,  3'd3, {3'd0,3'd0,3'd4,3'd1,3'd1}, 3'd3, {3'd2,3'd1,3'd1,3'd0,3'd0}}, // R5 two pairs + branch
        '{4'd5,  3'd4, {3'd0,3'd1,3'd0,3'd0,3'd0}, 3'd3, {3'd7,3'd7,3'd2,3'd1,3'd0}}, // R5 pair no room
        '{4'd7,  3'd2, {3'd0,3'd0,3'd0,3'd4,3'd3}, 3'd2, {3'd1,3'd7,3'd7,3'd7,3'd0}}, // R7 head + branch
        '{4'd1,  3'd7, {3'd4,3'd0,3'd0,3'd0,3'd0}, 3'd5, {3'd4,3'd3,3'd2,3'd1,3'd0}}  // R1 count clamp
    };

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic [2:0]                    win_count = '0;
    logic [4:0][2:0]               win_kind = '0;
    logic [4:0][CLU_W-1:0]         win_cluster = '0;
    logic [4:0][TAG_W-1:0]         win_tag = '0;
    logic [2:0]                    take_count;
    logic [4:0]                    grp_valid;
    logic [4:0][2:0]               grp_kind;
    logic [4:0][CLU_W-1:0]         grp_cluster;
    logic [4:0][TAG_W-1:0]         grp_tag;
    logic [4:0]                    grp_unit;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    dispatch_group_alloc #(.TAG_W(TAG_W), .CLU_W(CLU_W)) u_dut (
        .clk(clk), .rst(rst), .win_count(win_count), .win_kind(win_kind),
        .win_cluster(win_cluster), .win_tag(win_tag), .take_count(take_count),
        .grp_valid(grp_valid), .grp_kind(grp_kind), .grp_cluster(grp_cluster),
        .grp_tag(grp_tag), .grp_unit(grp_unit)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_vec(input int v);
        win_count = VECS[v].cnt;
        for (int i = 0; i < 5; i++) begin
            win_kind[i]    = VECS[v].kinds[3*i +: 3];
            win_tag[i]     = TAG_W'((v << 4) | i);
            win_cluster[i] = CLU_W'((i + v) % 3);
        end
    endtask

    // slot word: {valid, kind, cluster, unit, tag}
    function automatic logic [31:0] slot_act(input int s);
        return {17'd0, grp_valid[s], grp_kind[s], grp_cluster[s], grp_unit[s], grp_tag[s]};
    endfunction

    function automatic logic [31:0] slot_exp(input int v, input int s);
        logic [2:0] op;
        op = VECS[v].map[3*s +: 3];
        if (op == 3'd7) return 32'd0;
        return {17'd0, 1'b1, VECS[v].kinds[3*op +: 3], CLU_W'((op + v) % 3),
                (s == 1 || s == 2), TAG_W'((v << 4) | op)};
    endfunction

    initial begin
        // Reset with a full window offered: nothing taken, group empty (R9)
        drive_vec(1);
        @(negedge clk);
        check("R9", "take during reset", 32'(take_count), 32'd0);
        @(posedge clk); #1;
        check("R9", "valid after reset", 32'(grp_valid), 32'd0);
        check("R9", "tags after reset", 32'(grp_tag), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive_vec(v);
            #1;
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d take", v),
                  32'(take_count), 32'(VECS[v].take));
            @(posedge clk); #1;
            for (int s = 0; s < 5; s++) begin
                check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d slot %0d", v, s + 1),
                      slot_act(s), slot_exp(v, s));
            end
        end

        // Steering check across all four low slots with single ops (R4)
        @(negedge clk);
        drive_vec(0);
        @(posedge clk); #1;
        check("R4", "unit bits", 32'(grp_unit), 32'b00110);

        // Reset mid-stream clears a loaded group and blocks taking (R9)
        @(negedge clk);
        rst = 1'b1;
        drive_vec(1);
        #1;
        check("R9", "take in mid reset", 32'(take_count), 32'd0);
        @(posedge clk); #1;
        check("R9", "valid after mid reset", 32'(grp_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R3", "take after reset release", 32'(take_count), 32'd5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule